// File: doc/BRIEF.md
# Result FIFO with Drain and Overflow Requests

This block buffers conversion results coming from an internal converter path until software or a DMA engine collects them. Results are written through a one-cycle valid strobe and read through a pop port. The head entry is visible combinationally on the pop data output, and the read pointer moves on the clock edge that follows a pop strobe. The number of stored entries is always available on a count output.

Two sticky status flags track the buffer. The overflow flag records that a result arrived while the buffer was full. That result is thrown away and the stored entries are kept. The drain flag tells the consumer that entries are waiting. A select bit routes the drain request to either an interrupt line or a DMA request line, and it also decides how the drain flag is cleared. In interrupt mode the flag is cleared by a software write-1. In DMA mode the hardware clears it when the buffer empties. An enable bit gates each request. The enables and the select bit sit in a small configuration register loaded by a write strobe. Flag clears use a separate write strobe with one write-1-to-clear bit per flag.

Top module: `res_fifo_req`

## Requirements
- R1: After a synchronous reset, `fill_count` is 0, both flags are 0, all three request outputs are 0, `pop_data` is 0, and the configuration bits are 0.
- R2: A result with `res_valid` high while `fill_count` is below DEPTH is stored at the tail and `fill_count` rises by one on the next clock edge. Results are popped in the order they were accepted, and `pop_data` always shows the oldest stored entry.
- R3: A result with `res_valid` high while `fill_count` equals DEPTH is discarded. `ovf_flag` is 1 after the next edge, and the stored entries and their order are unchanged.
- R4: `ovf_irq` is high exactly when `ovf_flag` and the overflow enable are both 1.
- R5: A clear write (`clr_wr`=1) with `clr_ovf`=1 clears `ovf_flag` on the next edge. With `clr_ovf`=0 the flag is unchanged. If an overflow happens in the same cycle as the clear, the flag stays set.
- R6: `drain_flag` is 1 in every cycle in which `fill_count` is nonzero.
- R7: With the drain enable and `drain_flag` both 1, `drain_irq` is high when the select bit is 0 and `drain_dma` is high when it is 1. Neither is high otherwise.
- R8: In interrupt mode (select 0), `drain_flag` stays set after the buffer empties, until a clear write with `clr_drain`=1. Such a write made while entries remain has no effect, and so does `clr_drain`=0.
- R9: In DMA mode (select 1), `drain_flag` follows "buffer non-empty": it clears by itself on the edge where the buffer becomes empty, and a clear write with `clr_drain`=1 is ignored.
- R10: A pop strobe on an empty buffer returns `pop_data` = 0 and changes neither the count nor the flags.
- R11: A push and a pop in the same cycle on a buffer that is neither empty nor full leave `fill_count` unchanged and keep FIFO order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | Converter result strobe |
| res_data | input | DW | Converter result value |
| pop_strobe | input | 1 | Remove the head entry |
| pop_data | output | DW | Head entry, 0 when empty |
| fill_count | output | $clog2(DEPTH+1) | Number of stored entries |
| cfg_wr | input | 1 | Load the three configuration bits |
| cfg_ovf_en | input | 1 | Overflow interrupt enable |
| cfg_drain_en | input | 1 | Drain request enable |
| cfg_dma_sel | input | 1 | Drain request type: 0 interrupt, 1 DMA |
| clr_wr | input | 1 | Flag clear write strobe |
| clr_ovf | input | 1 | Write-1 clears the overflow flag |
| clr_drain | input | 1 | Write-1 clears the drain flag (interrupt mode only) |
| ovf_flag | output | 1 | Overflow flag |
| drain_flag | output | 1 | Drain flag |
| ovf_irq | output | 1 | Overflow interrupt request |
| drain_irq | output | 1 | Drain interrupt request |
| drain_dma | output | 1 | Drain DMA request |

## Verification
The bench builds the block with DEPTH=5 and DW=12. A depth of 5 is not a power of two, so the pointer wrap-around path is used, and the buffer fills after five pushes, which makes overflow bursts and same-cycle set/clear collisions cheap to reach. The 12-bit width lets each stored result carry a distinct tag, so a dropped or reordered entry is caught at the pop port. A long stretch of mixed random traffic with mode switches crosses the interrupt-mode and DMA-mode drain-flag rules while the buffer holds entries and while it is empty.

// File: rtl/res_fifo_pkg.sv
package res_fifo_pkg;
  typedef struct packed {
    logic ovf_en;
    logic drain_en;
    logic dma_sel;
  } rf_cfg_t;
endpackage

// File: rtl/res_fifo_cfg.sv
module res_fifo_cfg
  import res_fifo_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    wr,
  input  rf_cfg_t wdata,
  output rf_cfg_t cfg
);
  always_ff @(posedge clk) begin
    if (rst) cfg <= '0;
    else if (wr) cfg <= wdata;
  end
endmodule

// File: rtl/res_fifo_store.sv
module res_fifo_store #(
  parameter int DEPTH = 4,
  parameter int DW    = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          drop
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_inc, rd_inc;
  logic          full, empty, push_ok, pop_ok;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push_valid & ~full;
  assign pop_ok  = pop_req & ~empty;
  assign drop    = push_valid & full;
  assign cnt_nxt = cnt + {{(CW-1){1'b0}}, push_ok} - {{(CW-1){1'b0}}, pop_ok};

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wr_inc = wr_ptr + 1'b1;
      assign rd_inc = rd_ptr + 1'b1;
    end else begin : g_wrap
      assign wr_inc = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_inc = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  // storage without reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_inc;
      if (pop_ok)  rd_ptr <= rd_inc;
      cnt <= cnt_nxt;
    end
  end

  assign pop_data = empty ? '0 : mem[rd_ptr];

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  assert_drop_keeps_R3: assert property (@(posedge clk) disable iff (rst)
    (push_valid && full && !pop_req) |=> (cnt == $past(cnt)));
  assert_empty_pop_R10: assert property (@(posedge clk) disable iff (rst)
    (pop_req && empty && !push_valid) |=> (cnt == '0));
  assert_pair_count_R11: assert property (@(posedge clk) disable iff (rst)
    (push_valid && pop_req && !full && !empty) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/res_fifo_flags.sv
module res_fifo_flags
  import res_fifo_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          drop,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cnt_nxt,
  input  logic          clr_wr,
  input  logic          clr_ovf,
  input  logic          clr_drain,
  input  rf_cfg_t       cfg,
  output logic          ovf_flag,
  output logic          drain_flag,
  output logic          ovf_irq,
  output logic          drain_irq,
  output logic          drain_dma
);
  logic ovf_kill, drain_kill, fill_nxt;

  assign ovf_kill   = clr_wr & clr_ovf;
  assign drain_kill = clr_wr & clr_drain & ~cfg.dma_sel;
  assign fill_nxt   = (cnt_nxt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag   <= 1'b0;
      drain_flag <= 1'b0;
    end else begin
      // set beats clear
      ovf_flag <= drop | (ovf_flag & ~ovf_kill);
      if (cfg.dma_sel) drain_flag <= fill_nxt;
      else             drain_flag <= fill_nxt | (drain_flag & ~drain_kill);
    end
  end

  assign ovf_irq   = ovf_flag & cfg.ovf_en;
  assign drain_irq = drain_flag & cfg.drain_en & ~cfg.dma_sel;
  assign drain_dma = drain_flag & cfg.drain_en & cfg.dma_sel;

  assert_ovf_set_R3: assert property (@(posedge clk) disable iff (rst)
    drop |=> ovf_flag);
  assert_ovf_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !(clr_wr && clr_ovf)) |=> ovf_flag);
  assert_nonempty_drain_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> drain_flag);
  assert_req_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(drain_irq && drain_dma));
  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (!cfg.dma_sel && drain_flag && !(clr_wr && clr_drain)) |=> drain_flag);
  assert_dma_tracks_R9: assert property (@(posedge clk) disable iff (rst)
    cfg.dma_sel |=> (drain_flag == (cnt != '0)));
endmodule

// File: rtl/res_fifo_req.sv
module res_fifo_req
  import res_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DW    = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          res_valid,
  input  logic [DW-1:0] res_data,
  input  logic          pop_strobe,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] fill_count,
  input  logic          cfg_wr,
  input  logic          cfg_ovf_en,
  input  logic          cfg_drain_en,
  input  logic          cfg_dma_sel,
  input  logic          clr_wr,
  input  logic          clr_ovf,
  input  logic          clr_drain,
  output logic          ovf_flag,
  output logic          drain_flag,
  output logic          ovf_irq,
  output logic          drain_irq,
  output logic          drain_dma
);
  rf_cfg_t       cfg_q, cfg_w;
  logic [CW-1:0] cnt_nxt;
  logic          drop;

  assign cfg_w = '{ovf_en: cfg_ovf_en, drain_en: cfg_drain_en, dma_sel: cfg_dma_sel};

  res_fifo_cfg u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wdata(cfg_w), .cfg(cfg_q)
  );

  res_fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst(rst),
    .push_valid(res_valid), .push_data(res_data),
    .pop_req(pop_strobe), .pop_data(pop_data),
    .cnt(fill_count), .cnt_nxt(cnt_nxt), .drop(drop)
  );

  res_fifo_flags #(.CW(CW)) u_flags (
    .clk(clk), .rst(rst), .drop(drop),
    .cnt(fill_count), .cnt_nxt(cnt_nxt),
    .clr_wr(clr_wr), .clr_ovf(clr_ovf), .clr_drain(clr_drain),
    .cfg(cfg_q),
    .ovf_flag(ovf_flag), .drain_flag(drain_flag),
    .ovf_irq(ovf_irq), .drain_irq(drain_irq), .drain_dma(drain_dma)
  );

  assert_ovf_req_R4: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |-> ovf_flag);
endmodule

// File: tb/res_fifo_req_bench.sv
`timescale 1ns/1ps
module res_fifo_req_bench;
  localparam int DEPTH = 5;
  localparam int DW    = 12;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic res_valid = 0, pop_strobe = 0, cfg_wr = 0, cfg_ovf_en = 0, cfg_drain_en = 0;
  logic cfg_dma_sel = 0, clr_wr = 0, clr_ovf = 0, clr_drain = 0;
  logic [DW-1:0] res_data = '0;
  logic [DW-1:0] pop_data;
  logic [CW-1:0] fill_count;
  logic ovf_flag, drain_flag, ovf_irq, drain_irq, drain_dma;

  always #5 clk = ~clk;

  res_fifo_req #(.DEPTH(DEPTH), .DW(DW)) u_res_fifo_req (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .pop_strobe(pop_strobe), .pop_data(pop_data), .fill_count(fill_count),
    .cfg_wr(cfg_wr), .cfg_ovf_en(cfg_ovf_en), .cfg_drain_en(cfg_drain_en),
    .cfg_dma_sel(cfg_dma_sel), .clr_wr(clr_wr), .clr_ovf(clr_ovf),
    .clr_drain(clr_drain), .ovf_flag(ovf_flag), .drain_flag(drain_flag),
    .ovf_irq(ovf_irq), .drain_irq(drain_irq), .drain_dma(drain_dma)
  );

  int checks = 0, failures = 0;
  int q[$];
  bit m_ovf, m_drain, m_oe, m_de, m_ds;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int exp_pd;
    exp_pd = (q.size() != 0) ? q[0] : 0;
    check(int'(fill_count) == q.size(), "R2 count", int'(fill_count), q.size());
    check(int'(pop_data) == exp_pd, "R2 head data", int'(pop_data), exp_pd);
    check(ovf_flag == m_ovf, "R3 ovf_flag", ovf_flag, m_ovf);
    check(drain_flag == m_drain, "R6 drain_flag", drain_flag, m_drain);
    check(ovf_irq == (m_ovf & m_oe), "R4 ovf_irq", ovf_irq, m_ovf & m_oe);
    check(drain_irq == (m_drain & m_de & !m_ds), "R7 drain_irq", drain_irq, m_drain & m_de & !m_ds);
    check(drain_dma == (m_drain & m_de & m_ds), "R7 drain_dma", drain_dma, m_drain & m_de & m_ds);
  endtask

  // one clock: drive inputs, compare state from the previous edge, advance model
  task automatic cyc(input bit iv, input int d, input bit pp, input bit cw, input bit oe,
                     input bit de, input bit ds, input bit xw, input bit xo, input bit xd);
    bit full, push_ok, pop_ok, set_ovf, nonempty;
    @(negedge clk);
    res_valid = iv; res_data = DW'(d); pop_strobe = pp;
    cfg_wr = cw; cfg_ovf_en = oe; cfg_drain_en = de; cfg_dma_sel = ds;
    clr_wr = xw; clr_ovf = xo; clr_drain = xd;
    #1;
    compare_all();
    full = (q.size() == DEPTH);
    push_ok = iv && !full;
    pop_ok = pp && (q.size() != 0);
    set_ovf = iv && full;
    if (pop_ok) void'(q.pop_front());
    if (push_ok) q.push_back(d & ((1 << DW) - 1));
    nonempty = (q.size() != 0);
    m_ovf = set_ovf || (m_ovf && !(xw && xo));
    if (m_ds) m_drain = nonempty;
    else      m_drain = nonempty || (m_drain && !(xw && xd));
    if (cw) begin m_oe = oe; m_de = de; m_ds = ds; end
  endtask

  task automatic idle();       cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic push(input int d); cyc(1, d, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic pop1();       cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic cfg(input bit oe, input bit de, input bit ds); cyc(0, 0, 0, 1, oe, de, ds, 0, 0, 0); endtask
  task automatic clr(input bit o, input bit d); cyc(0, 0, 0, 0, 0, 0, 0, 1, o, d); endtask
  task automatic settle(); @(posedge clk); #2; endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    // R1 reset state
    check(fill_count == 0 && pop_data == 0, "R1 fifo reset", int'(fill_count), 0);
    check(!ovf_flag && !drain_flag && !ovf_irq && !drain_irq && !drain_dma,
          "R1 flags reset", int'({ovf_flag, drain_flag, ovf_irq, drain_irq, drain_dma}), 0);

    // interrupt mode, both enables
    cfg(1, 1, 0);
    push(12'h101); push(12'h102); push(12'h103);
    settle();
    check(drain_irq && !drain_dma, "R7 irq routing", int'({drain_irq, drain_dma}), 2);
    check(pop_data == 12'h101, "R2 oldest at head", int'(pop_data), 'h101);
    push(12'h104); push(12'h105);
    push(12'h1AA); push(12'h1BB);          // dropped
    settle();
    check(ovf_flag && fill_count == DEPTH, "R3 overflow sets, count kept", int'(fill_count), DEPTH);
    check(pop_data == 12'h101, "R3 head untouched", int'(pop_data), 'h101);
    check(ovf_irq == 1, "R4 ovf_irq", ovf_irq, 1);
    clr(0, 0);
    settle();
    check(ovf_flag == 1, "R5 write 0 no effect", ovf_flag, 1);
    cyc(1, 12'h1CC, 0, 0, 0, 0, 0, 1, 1, 0); // clear and overflow together
    settle();
    check(ovf_flag == 1, "R5 set wins", ovf_flag, 1);
    clr(1, 0);
    settle();
    check(ovf_flag == 0 && ovf_irq == 0, "R5 w1c clears", ovf_flag, 0);
    clr(0, 1);                             // drain clear while entries remain
    settle();
    check(drain_flag == 1, "R8 clear ignored while non-empty", drain_flag, 1);
    cyc(1, 12'h1DD, 1, 0, 0, 0, 0, 0, 0, 0); // full: push dropped, pop taken
    pop1();
    cyc(1, 12'h106, 1, 0, 0, 0, 0, 0, 0, 0);
    settle();
    check(fill_count == 3 && pop_data == 12'h104, "R11 push+pop keeps count", int'(fill_count), 3);
    pop1(); pop1(); pop1();
    settle();
    check(fill_count == 0 && drain_flag == 1, "R8 sticky after empty", drain_flag, 1);
    clr(0, 0);
    settle();
    check(drain_flag == 1, "R8 write 0 no effect", drain_flag, 1);
    clr(0, 1);
    settle();
    check(drain_flag == 0 && drain_irq == 0, "R8 w1c clears when empty", drain_flag, 0);
    pop1();
    settle();
    check(pop_data == 0 && fill_count == 0 && !drain_flag, "R10 empty pop", int'(pop_data), 0);

    // DMA mode
    cfg(1, 1, 1);
    push(12'h201); push(12'h202);
    settle();
    check(drain_dma && !drain_irq, "R7 dma routing", int'({drain_irq, drain_dma}), 1);
    clr(0, 1);
    settle();
    check(drain_flag == 1, "R9 sw clear ignored", drain_flag, 1);
    pop1(); pop1();
    settle();
    check(drain_flag == 0 && drain_dma == 0, "R9 auto clear on empty", drain_flag, 0);
    cfg(0, 0, 1);
    push(12'h203);
    settle();
    check(!drain_irq && !drain_dma, "R7 enable gates", int'({drain_irq, drain_dma}), 0);

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      cyc(r[0] | r[1], r[27:16], r[2] & r[3], (r[15:10] == 0), r[4], r[5], r[6],
          r[7] & r[8], r[9], r[11]);
    end
    idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule